// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Holding Register

This block turns bytes from a parallel write port into asynchronous serial frames on a single output line. A frame opens with a low start bit, carries 5 to 8 data bits least significant first, may add an even or odd parity bit, and closes with a high stop bit. When no frame is in flight the line rests high.

There are two storage stages. A holding register accepts one byte while the previous byte is still being shifted out. The writer uses the hold-empty flag to see when a write will be taken. A write pulse is also the start command: a byte written while the transmitter is idle goes out at once. If a byte is waiting when a stop bit ends, its start bit follows with no idle time between the frames.

Bit timing comes from an internal divider. It produces one tick every `DIV` clocks, which is sixteen ticks per bit period. The divider restarts with every frame, so each bit lasts exactly `16*DIV` clocks. Frame length and parity mode are taken from the configuration inputs at the moment a byte moves into the shifter.

Top module: `uart_frame_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `txd` is 1, `busy` is 0 and `hold_empty` is 1.
- R2: A write (`wr_en`=1 with `hold_empty`=1) is seen at one clock edge and clears `hold_empty` after that edge. If the transmitter is idle, the next edge starts the frame: `txd` goes to 0 and `busy` goes to 1, and `hold_empty` returns to 1.
- R3: Every bit of a frame, including the start and stop bits, holds `txd` for exactly `16*DIV` clock cycles.
- R4: The number of data bits is `5 + len_sel`, so `len_sel` values 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. Data bits follow the start bit, `wr_data[0]` first. Bits of `wr_data` above that length are not sent.
- R5: When `par_en`=1, one parity bit follows the last data bit. It is the XOR of the data bits sent, inverted when `par_odd`=1. When `par_en`=0 no parity bit is sent.
- R6: The final bit of a frame is a stop bit at 1. If no byte is waiting when it ends, `busy` drops to 0 and `txd` stays 1.
- R7: A write while `hold_empty`=0 is ignored. The waiting byte is not replaced and the next frame carries the earlier byte.
- R8: If a byte is waiting when the stop bit ends, its start bit begins on the very next cycle. `busy` stays 1 and there is no idle-high period.
- R9: `len_sel`, `par_en` and `par_odd` are sampled when a byte enters the shifter. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write / start pulse for the holding register |
| wr_data | input | 8 | Byte to send |
| len_sel | input | 2 | Data length select; length is 5 + value |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| hold_empty | output | 1 | Holding register can accept a write |
| busy | output | 1 | A frame is on the line |
| txd | output | 1 | Serial output, idle high |

## Verification
Timing is counted from the edge that samples a write. `hold_empty` falls after that edge, and the start bit and `busy` appear one edge later. Each following bit changes exactly `16*DIV` edges after the one before it, and a waiting byte's start bit comes on the same edge the previous stop bit ends. A behavioural model in the bench steps forward at each rising edge and is compared with all three outputs at every falling edge. Directed checks sample each bit at the middle of its period, counted from the falling edge after the start bit begins, and sample the exact edge where the first bit period ends.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_MAX = 8;
  localparam int FRAME_W  = DATA_MAX + 3;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
  } tx_cfg_t;

  function automatic int data_bits(input logic [1:0] len);
    return 5 + int'(len);
  endfunction

  function automatic logic par_bit(input logic [DATA_MAX-1:0] d,
                                   input logic [1:0] len,
                                   input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < data_bits(len)) p = p ^ d[i];
    return p;
  endfunction

  function automatic logic [3:0] frame_len(input tx_cfg_t c);
    return 4'(data_bits(c.len) + 2 + int'(c.par_en));
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_MAX-1:0] d,
                                                     input tx_cfg_t c);
    logic [FRAME_W-1:0] f;
    int nd;
    nd   = data_bits(c.len);
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < nd) f[i+1] = d[i];
    if (c.par_en) f[nd+1] = par_bit(d, c.len, c.par_odd);
    return f;
  endfunction

endpackage

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
  parameter int DIV = 4,
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick,
  output logic bit_end
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TW = $clog2(OVS);
  localparam logic [DW-1:0] CMAX = DW'(DIV - 1);
  localparam logic [TW-1:0] TMAX = TW'(OVS - 1);

  logic [DW-1:0] cnt;
  logic [TW-1:0] tcnt;

  assign tick    = run && (cnt == CMAX);
  assign bit_end = tick && (tcnt == TMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      tcnt <= '0;
    end else if (restart) begin
      cnt  <= '0;
      tcnt <= '0;
    end else if (run) begin
      cnt <= (cnt == CMAX) ? '0 : cnt + 1'b1;
      if (tick) tcnt <= (tcnt == TMAX) ? '0 : tcnt + 1'b1;
    end
  end

  AST_SUBTICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(tcnt)); // R3

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  logic accept;
  assign accept = wr_en && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (accept) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !take) |=> $stable(data)); // R7

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                bit_end,
  input  tx_cfg_t             cfg,
  input  logic [DATA_MAX-1:0] data_in,
  output logic                busy,
  output logic                frame_end,
  output logic                txd
);
  logic [FRAME_W-1:0] sreg;
  logic [3:0]         left;

  assign frame_end = busy && bit_end && (left == 4'd1);
  assign txd       = sreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sreg <= build_frame(data_in, cfg);
      left <= frame_len(cfg);
      busy <= 1'b1;
    end else if (frame_end) begin
      sreg <= '1;
      left <= '0;
      busy <= 1'b0;
    end else if (busy && bit_end) begin
      sreg <= {1'b1, sreg[FRAME_W-1:1]};
      left <= left - 4'd1;
    end
  end

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R6
  AST_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd); // R2
  AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end && !load) |=> $stable(sreg)); // R9

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  output logic       hold_empty,
  output logic       busy,
  output logic       txd
);
  localparam int OVS = 16;

  logic                hold_full;
  logic [DATA_MAX-1:0] hold_data;
  logic                load;
  logic                tick;
  logic                bit_end;
  logic                frame_end;
  tx_cfg_t             cfg;

  assign cfg        = '{len: len_sel, par_en: par_en, par_odd: par_odd};
  assign load       = hold_full && (!busy || frame_end);
  assign hold_empty = !hold_full;

  uart_tx_hold #(.DW(DATA_MAX)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(load), .full(hold_full), .data(hold_data)
  );

  uart_tx_tick #(.DIV(DIV), .OVS(OVS)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .restart(load),
    .tick(tick), .bit_end(bit_end)
  );

  uart_tx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .bit_end(bit_end),
    .cfg(cfg), .data_in(hold_data), .busy(busy),
    .frame_end(frame_end), .txd(txd)
  );

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && hold_full) |=> (busy && !txd)); // R8
  AST_TICK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy); // R3

endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  localparam int DIV = 2;
  localparam int B   = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       hold_empty, busy, txd;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  uart_frame_tx #(.DIV(DIV)) u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .hold_empty(hold_empty), .busy(busy), .txd(txd)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_full = 0;
  bit [7:0] m_byte = 0;
  bit m_busy = 0;
  bit m_bits[$];
  int m_cnt = 0;

  function automatic int nbits(input logic [1:0] l);
    return 5 + l;
  endfunction

  function automatic bit exp_bit(input logic [7:0] d, input logic [1:0] l,
                                 input bit pe, input bit po, input int k);
    int ones = 0;
    if (k == 0) return 1'b0;
    if (k <= nbits(l)) return d[k-1];
    if (pe && k == nbits(l) + 1) begin
      for (int i = 0; i < nbits(l); i++) ones += d[i];
      return (ones % 2 == 1) ^ po;
    end
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_full = 0; m_busy = 0; m_cnt = 0; m_bits.delete();
    end else begin
      bit load_now, acc;
      load_now = 0;
      acc = wr_en && !m_full;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == B) begin
          m_cnt = 0;
          void'(m_bits.pop_front());
          if (m_bits.size() == 0) begin
            if (m_full) load_now = 1; else m_busy = 0;
          end
        end
      end else if (m_full) load_now = 1;
      if (load_now) begin
        int n;
        n = 2 + nbits(len_sel) + par_en;
        m_bits.delete();
        for (int k = 0; k < n; k++) m_bits.push_back(exp_bit(m_byte, len_sel, par_en, par_odd, k));
        m_busy = 1; m_cnt = 0; m_full = 0;
      end
      if (acc) begin m_full = 1; m_byte = wr_data; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3/R4/R8 model txd", txd, m_busy ? m_bits[0] : 1'b1);
      check("R6 model busy", busy, m_busy);
      check("R2/R7 model hold_empty", hold_empty, !m_full);
    end
  end

  // Drive a byte from idle and check the start timing (R2).
  task automatic start_frame(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 hold_empty after write", hold_empty, 1'b0);
    check("R2 line still idle", txd, 1'b1);
    @(negedge clk);
    check("R2 start bit", txd, 1'b0);
    check("R2 busy at start", busy, 1'b1);
    check("R2 hold freed", hold_empty, 1'b1);
  endtask

  // Walk one frame from the falling edge after its start bit began.
  task automatic walk_frame(input logic [7:0] d, input logic [1:0] l, input bit pe,
                            input bit po, input bit inj, input logic [7:0] a,
                            input logic [7:0] b, input bit chg, input bit follow);
    int n;
    n = 2 + nbits(l) + pe;
    for (int c = 1; c <= n * B; c++) begin
      @(negedge clk);
      if (inj && c == 5) begin wr_data = a; wr_en = 1'b1; end
      if (inj && c == 6) begin
        check("R7 hold full after write", hold_empty, 1'b0);
        wr_data = b;
      end
      if (inj && c == 7) wr_en = 1'b0;
      if (inj && c == 8) check("R7 still full after ignored write", hold_empty, 1'b0);
      if (chg && c == 20) begin len_sel = 2'd0; par_en = 1'b0; par_odd = 1'b1; end
      if (c == B - 1) check("R3 start bit lasts full period", txd, 1'b0);
      if (c == B && d[0]) check("R3 first data bit on time", txd, 1'b1);
      if (c % B == B / 2) begin
        int k;
        k = c / B;
        if (k == 0) check("R2 start mid", txd, 1'b0);
        else if (k <= nbits(l)) check("R4 data bit", txd, exp_bit(d, l, pe, po, k));
        else if (pe && k == nbits(l) + 1) check("R5 parity bit", txd, exp_bit(d, l, pe, po, k));
        else check("R6 stop bit", txd, 1'b1);
      end
    end
    if (follow) begin
      check("R8 next start immediate", txd, 1'b0);
      check("R8 busy held", busy, 1'b1);
    end else begin
      check("R6 idle after stop", txd, 1'b1);
      check("R6 busy dropped", busy, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset txd", txd, 1'b1);
    check("R1 reset busy", busy, 1'b0);
    check("R1 reset hold_empty", hold_empty, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release txd", txd, 1'b1);
    check("R1 after release hold_empty", hold_empty, 1'b1);

    len_sel = 2'd3; par_en = 0; par_odd = 0;
    start_frame(8'hA5);
    walk_frame(8'hA5, 2'd3, 0, 0, 0, 8'h00, 8'h00, 0, 0);

    len_sel = 2'd0; par_en = 1; par_odd = 0;
    start_frame(8'h13);
    walk_frame(8'h13, 2'd0, 1, 0, 0, 8'h00, 8'h00, 0, 0);

    len_sel = 2'd2; par_en = 1; par_odd = 1;
    start_frame(8'h6E);
    walk_frame(8'h6E, 2'd2, 1, 1, 0, 8'h00, 8'h00, 0, 0);

    len_sel = 2'd1; par_en = 1; par_odd = 1;
    start_frame(8'hFF);
    walk_frame(8'hFF, 2'd1, 1, 1, 0, 8'h00, 8'h00, 0, 0);

    // R7 and R8: a waiting byte, an ignored write, and no gap between frames
    len_sel = 2'd3; par_en = 0; par_odd = 0;
    start_frame(8'h3C);
    walk_frame(8'h3C, 2'd3, 0, 0, 1, 8'h81, 8'h7E, 0, 1);
    walk_frame(8'h81, 2'd3, 0, 0, 0, 8'h00, 8'h00, 0, 0);

    // R9: configuration change during a frame
    len_sel = 2'd3; par_en = 1; par_odd = 0;
    start_frame(8'h5A);
    walk_frame(8'h5A, 2'd3, 1, 0, 0, 8'h00, 8'h00, 1, 0);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule